// File: doc/BRIEF.md
# Return-Path Double-Trap Flag Clearing Unit

This unit decides, for every trap-return instruction, which supervisor double-trap flags the status write of that return must clear. The core drives a one-hot strobe naming the return kind: machine return, supervisor return or debug-mode exit. Alongside the strobe it drives the privilege and virtualization state the hart is leaving and the state it is returning to. The core takes that target from the machine-level previous-mode fields, from the supervisor-level previous-mode fields, or from the privilege and virtualization fields saved in the debug control register.

The flags are never restored from a saved copy. Each one is either cleared or left untouched, and the choice depends on the return kind and on the target mode. The unit produces two clear enables. One is for the host-supervisor flag, which lives in the machine status register. The other is for the virtual-supervisor status flag. Both enables are registered into the same cycle as a single status-commit pulse, so they land together with the rest of the return's status update.

A two-state machine does the sequencing. The states are `ST_IDLE` (no update pending) and `ST_COMMIT` (status write issued this cycle). There are two transitions. `ACCEPT` goes from either state to `ST_COMMIT` on a legal strobe. `DRAIN` goes from either state to `ST_IDLE` when no legal strobe is present. A legal strobe in `ST_COMMIT` therefore starts the next commit directly.

Top module: `ret_sdt_clear`

## Requirements
- R1: Out of reset, and in any cycle with no pending return, `status_commit_o`, `clr_hs_sdt_o` and `clr_vs_sdt_o` are all 0.
- R2: A machine return (strobe bit 0) sets `clr_hs_sdt_o` when the target privilege is user (code 0) or the target is virtualized.
- R3: A machine return also sets `clr_vs_sdt_o` only when the target is virtualized user mode. A return to virtualized supervisor (code 1) clears the host flag but not the virtual flag.
- R4: A debug exit (strobe bit 2) applies the same two rules as R2 and R3, using the target fields taken from the debug control register.
- R5: A supervisor return (strobe bit 1) executed at supervisor privilege clears the flag of the current supervisor status. From HS-mode (virt 0) this is `clr_hs_sdt_o`. From VS-mode (virt 1) this is `clr_vs_sdt_o`, and `clr_hs_sdt_o` stays 0.
- R6: A supervisor return executed in HS-mode whose target is virtualized user mode sets both `clr_hs_sdt_o` and `clr_vs_sdt_o`.
- R7: A supervisor return executed at machine privilege (code 3) clears neither flag, although it still commits.
- R8: Any return matching none of the clear conditions commits with both enables 0. This covers, for example, a machine return to non-virtual supervisor or to machine mode.
- R9: A legal strobe in cycle N produces exactly one `status_commit_o` pulse in cycle N+1. The clear enables are asserted only in a commit cycle. Back-to-back strobes give back-to-back commits.
- R10: A strobe with zero bits or with more than one bit set produces no commit and no clear in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ret_strobe_i | input | 3 | One-hot return kind: bit 0 machine return, bit 1 supervisor return, bit 2 debug exit |
| cur_priv_i | input | PRIV_W | Privilege being left: 0 user, 1 supervisor, 3 machine |
| cur_virt_i | input | 1 | Virtualization state being left |
| tgt_priv_i | input | PRIV_W | Privilege being returned to |
| tgt_virt_i | input | 1 | Virtualization state being returned to |
| status_commit_o | output | 1 | Status-write pulse of the return |
| clr_hs_sdt_o | output | 1 | Clear enable for the host-supervisor double-trap flag |
| clr_vs_sdt_o | output | 1 | Clear enable for the virtual-supervisor double-trap flag |

## Verification
The bench builds the unit with its default privilege width of two bits. This makes the reserved privilege code 2 reachable in both the current and the target fields, next to the user, supervisor and machine codes. Random stimulus covers every strobe pattern, including zero and multi-bit strobes, and every privilege and virtualization pairing. Strobes come both in consecutive cycles and separated by idle cycles, so the `ACCEPT` transition is exercised from `ST_IDLE` and from `ST_COMMIT`, and so is `DRAIN`.

// File: rtl/ret_sdt_pkg.sv
package ret_sdt_pkg;

    localparam int STROBE_W    = 3;
    localparam int STB_MACHINE = 0;
    localparam int STB_SUPER   = 1;
    localparam int STB_DEBUG   = 2;

    localparam logic [1:0] PRIV_USER    = 2'd0;
    localparam logic [1:0] PRIV_SUPER   = 2'd1;
    localparam logic [1:0] PRIV_MACHINE = 2'd3;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } commit_state_e;

    typedef struct packed {
        logic hs;
        logic vs;
    } sdt_clr_t;

endpackage

// File: rtl/ret_sdt_decode.sv
module ret_sdt_decode
    import ret_sdt_pkg::*;
#(
    parameter int PRIV_W = 2
) (
    input  logic [STROBE_W-1:0] strobe_i,
    input  logic [PRIV_W-1:0]   cur_priv_i,
    input  logic                cur_virt_i,
    input  logic [PRIV_W-1:0]   tgt_priv_i,
    input  logic                tgt_virt_i,
    output logic                legal_o,
    output sdt_clr_t            clr_o
);

    localparam logic [PRIV_W-1:0] P_USER  = PRIV_W'(PRIV_USER);
    localparam logic [PRIV_W-1:0] P_SUPER = PRIV_W'(PRIV_SUPER);

    logic tgt_user;
    logic tgt_vuser;
    logic cur_super;
    sdt_clr_t mach_clr;
    sdt_clr_t sup_clr;

    assign tgt_user  = (tgt_priv_i == P_USER);
    assign tgt_vuser = tgt_user && tgt_virt_i;
    assign cur_super = (cur_priv_i == P_SUPER);
    assign legal_o   = ($countones(strobe_i) == 1);

    // Machine return and debug exit share one rule set.
    always_comb begin
        mach_clr.hs = tgt_user || tgt_virt_i;
        mach_clr.vs = tgt_vuser;
    end

    // Supervisor return: acts only when executed at supervisor privilege.
    always_comb begin
        sup_clr = '0;
        if (cur_super) begin
            if (cur_virt_i) begin
                sup_clr.vs = 1'b1;
            end else begin
                sup_clr.hs = 1'b1;
                sup_clr.vs = tgt_vuser;
            end
        end
    end

    always_comb begin
        clr_o = '0;
        if (legal_o) begin
            unique case (1'b1)
                strobe_i[STB_MACHINE],
                strobe_i[STB_DEBUG]:   clr_o = mach_clr;
                strobe_i[STB_SUPER]:   clr_o = sup_clr;
                default:               clr_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/ret_sdt_commit.sv
module ret_sdt_commit
    import ret_sdt_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     legal_i,
    input  sdt_clr_t clr_i,
    output logic     commit_o,
    output sdt_clr_t clr_o
);

    commit_state_e state_q, state_d;
    sdt_clr_t      held_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = legal_i ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = legal_i ? ST_COMMIT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= legal_i ? clr_i : '0;
        end
    end

    always_comb begin
        commit_o = 1'b0;
        clr_o    = '0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_COMMIT: begin
                commit_o = 1'b1;
                clr_o    = held_q;
            end
            default:   ;
        endcase
    end

    // R9
    clr_needs_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_o.hs || clr_o.vs) |-> commit_o);

    // R10
    commit_after_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_o |-> $past(legal_i));

endmodule

// File: rtl/ret_sdt_clear.sv
module ret_sdt_clear
    import ret_sdt_pkg::*;
#(
    parameter int PRIV_W = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [STROBE_W-1:0] ret_strobe_i,
    input  logic [PRIV_W-1:0]   cur_priv_i,
    input  logic                cur_virt_i,
    input  logic [PRIV_W-1:0]   tgt_priv_i,
    input  logic                tgt_virt_i,
    output logic                status_commit_o,
    output logic                clr_hs_sdt_o,
    output logic                clr_vs_sdt_o
);

    logic     legal;
    sdt_clr_t dec_clr;
    sdt_clr_t out_clr;

    ret_sdt_decode #(.PRIV_W(PRIV_W)) u_decode (
        .strobe_i   (ret_strobe_i),
        .cur_priv_i (cur_priv_i),
        .cur_virt_i (cur_virt_i),
        .tgt_priv_i (tgt_priv_i),
        .tgt_virt_i (tgt_virt_i),
        .legal_o    (legal),
        .clr_o      (dec_clr)
    );

    ret_sdt_commit u_commit (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .legal_i  (legal),
        .clr_i    (dec_clr),
        .commit_o (status_commit_o),
        .clr_o    (out_clr)
    );

    assign clr_hs_sdt_o = out_clr.hs;
    assign clr_vs_sdt_o = out_clr.vs;

    // R7
    sret_from_m_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_commit_o && $past(ret_strobe_i == 3'b010)
         && $past(cur_priv_i == PRIV_W'(PRIV_MACHINE)))
        |-> (!clr_hs_sdt_o && !clr_vs_sdt_o));

    // R3
    mret_to_vs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_commit_o && $past(ret_strobe_i == 3'b001) && $past(tgt_virt_i)
         && $past(tgt_priv_i == PRIV_W'(PRIV_SUPER)))
        |-> (clr_hs_sdt_o && !clr_vs_sdt_o));

    // R6
    sret_hs_to_vu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_commit_o && $past(ret_strobe_i == 3'b010)
         && $past(cur_priv_i == PRIV_W'(PRIV_SUPER)) && $past(!cur_virt_i)
         && $past(tgt_virt_i) && $past(tgt_priv_i == PRIV_W'(PRIV_USER)))
        |-> (clr_hs_sdt_o && clr_vs_sdt_o));

    // R9
    one_commit_per_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(ret_strobe_i) == 1) |=> status_commit_o);

endmodule

// File: tb/ret_sdt_clear_tb_top.sv
module ret_sdt_clear_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] stb = '0;
    logic [1:0] cpriv = '0;
    logic       cvirt = 1'b0;
    logic [1:0] tpriv = '0;
    logic       tvirt = 1'b0;
    logic       commit, chs, cvs;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    ret_sdt_clear #(.PRIV_W(2)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ret_strobe_i(stb),
        .cur_priv_i(cpriv), .cur_virt_i(cvirt),
        .tgt_priv_i(tpriv), .tgt_virt_i(tvirt),
        .status_commit_o(commit), .clr_hs_sdt_o(chs), .clr_vs_sdt_o(cvs)
    );

    function automatic logic [2:0] model(input logic [2:0] s, input logic [1:0] cp,
                                          input logic cv, input logic [1:0] tp,
                                          input logic tv);
        logic hs, vs;
        hs = 1'b0; vs = 1'b0;
        if (!($countones(s) == 1)) return 3'b000;
        if (s[0] || s[2]) begin
            hs = (tp == 2'd0) || tv;
            vs = (tp == 2'd0) && tv;
        end else if (cp == 2'd1) begin
            if (cv) vs = 1'b1;
            else begin
                hs = 1'b1;
                vs = (tp == 2'd0) && tv;
            end
        end
        return {1'b1, hs, vs};
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        checks++;
        if ({commit, chs, cvs} !== exp) begin
            errors++;
            $display("FAIL %s: got commit/hs/vs=%b expected %b", req, {commit, chs, cvs}, exp);
        end
    endtask

    // drive at negedge, check at the following negedge
    task automatic step(input string req, input logic [2:0] s, input logic [1:0] cp,
                        input logic cv, input logic [1:0] tp, input logic tv);
        stb = s; cpriv = cp; cvirt = cv; tpriv = tp; tvirt = tv;
        @(negedge clk);
        check(req, model(s, cp, cv, tp, tv));
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        repeat (3) @(negedge clk);
        check("R1 reset", 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", 3'b000);
        // directed
        step("R2 mret to U",           3'b001, 2'd3, 1'b0, 2'd0, 1'b0);
        step("R3 mret to VU",          3'b001, 2'd3, 1'b0, 2'd0, 1'b1);
        step("R3 mret to VS",          3'b001, 2'd3, 1'b0, 2'd1, 1'b1);
        step("R8 mret to S",           3'b001, 2'd3, 1'b0, 2'd1, 1'b0);
        step("R8 mret to M",           3'b001, 2'd3, 1'b0, 2'd3, 1'b0);
        step("R4 dret to VU",          3'b100, 2'd3, 1'b0, 2'd0, 1'b1);
        step("R4 dret to S",           3'b100, 2'd3, 1'b0, 2'd1, 1'b0);
        step("R4 dret to U",           3'b100, 2'd3, 1'b0, 2'd0, 1'b0);
        step("R5 sret in HS",          3'b010, 2'd1, 1'b0, 2'd1, 1'b0);
        step("R5 sret in VS",          3'b010, 2'd1, 1'b1, 2'd0, 1'b1);
        step("R6 sret HS to VU",       3'b010, 2'd1, 1'b0, 2'd0, 1'b1);
        step("R7 sret from M",         3'b010, 2'd3, 1'b0, 2'd0, 1'b1);
        step("R10 zero strobe",        3'b000, 2'd3, 1'b0, 2'd0, 1'b1);
        step("R10 two-bit strobe",     3'b011, 2'd1, 1'b0, 2'd0, 1'b1);
        step("R9 back to back",        3'b001, 2'd3, 1'b0, 2'd0, 1'b1);
        step("R9 back to back",        3'b001, 2'd3, 1'b0, 2'd0, 1'b0);
        step("R9 drain",               3'b000, 2'd0, 1'b0, 2'd0, 1'b0);
        // random
        seed = $urandom(32'h5d7);
        for (int i = 0; i < 400; i++) begin
            logic [2:0] s;
            int k;
            k = $urandom_range(0, 9);
            if (k < 7) s = 3'b001 << (k % 3);
            else if (k == 7) s = 3'b000;
            else s = 3'($urandom_range(0, 7));
            step("R2 R4 R5 R6 R7 R8 R9 R10 random", s, 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)));
        end
        stb = '0;
        @(negedge clk);
        check("R1 final idle", 3'b000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule